// File: doc/BRIEF.md
# Dual-Format Serial Register Slave

This block is a serial-bus target for mode 0 (clock idle low, data captured on the rising edge, most significant bit first). It turns serial commands into accesses on a simple synchronous register and memory port: an address, a space select, write data, a write strobe, a read strobe and read data. The three serial pins are brought into the system clock domain through two-flop synchronizers. The system clock must run at least 8 times faster than the serial clock.

Two command formats share the bus, and the top bit of the first byte selects between them. A short command is one byte and reaches a 64-entry space. A long command is two bytes and reaches a 1024-entry space that holds both registers and frame buffers. The data bytes follow the command. While chip select stays low, each further data byte goes to the next address in the same space, for writes and for reads, and the address wraps at the end of that space. Read data is fetched as soon as the command, or the previous data byte, completes. It is then shifted out on MISO during the next byte.

The controller has five states:
- `ST_IDLE`: chip select is high.
- `ST_CMD_HI`: the first command byte is arriving.
- `ST_CMD_LO`: the second byte of a long command is arriving.
- `ST_WR_DATA`: write data bytes are arriving.
- `ST_RD_DATA`: read data bytes are being sent.

The transitions are:
- `ST_IDLE` goes to `ST_CMD_HI` when chip select falls.
- `ST_CMD_HI` goes to `ST_CMD_LO` when the completed byte has bit 7 set.
- `ST_CMD_HI` goes to `ST_WR_DATA` or `ST_RD_DATA` when the completed byte has bit 7 clear, chosen by its bit 0.
- `ST_CMD_LO` goes to `ST_WR_DATA` or `ST_RD_DATA` when its byte completes, chosen by bit 4 of that byte.
- The two data states loop on themselves.
- Every state returns to `ST_IDLE` when chip select rises.

Top module: `spi_dual_reg_slave`

## Requirements
- R1: A first byte with bit 7 clear is a short command. Bits 6:1 give the address, and bit 0 set means write. The access uses `reg_space`=0, with the address in `reg_addr[5:0]` and the upper address bits zero.
- R2: A first byte with bit 7 set starts a 16-bit long command. Bit 15 of the command is 1, bits 14:5 give the 10-bit address, and bit 4 set means write. Bits 3:0 have no effect on the access. The access uses `reg_space`=1.
- R3: Each completed write data byte gives exactly one single-cycle `reg_we` pulse. The pulse carries that byte on `reg_wdata`, and `reg_addr` is stable while it is high.
- R4: The data bytes of a write burst go to consecutive addresses, wrapping modulo 64 in the short space and modulo 1024 in the long space.
- R5: In a read, the byte after the command returns the addressed entry on MISO, most significant bit first. Each bit is valid at the rising serial clock edge. `reg_re` is a single-cycle pulse, and `reg_rdata` is taken in the cycle after it.
- R6: The data bytes of a read burst return consecutive entries, with the same wrap as R4.
- R7: Chip select going high aborts the transfer. A partly received byte causes no strobe, and the next transfer starts again with a command byte.
- R8: After reset and while chip select is high, MISO is 0 and neither strobe is active.
- R9: `reg_we` and `reg_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| reg_addr | output | 10 | Entry address |
| reg_space | output | 1 | 0 = short space, 1 = long space |
| reg_wdata | output | 8 | Write data |
| reg_we | output | 1 | Write strobe, one cycle |
| reg_re | output | 1 | Read strobe, one cycle |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_re` |

## Verification
A rising serial edge shows up as an internal pulse 2 cycles after it reaches the pin. The byte-complete flag follows 1 cycle later, and any strobe 1 cycle after that, so it comes 4 system cycles after the eighth rising edge. Read data lands in the transmit shifter 6 cycles after that edge. The next bit appears 3 cycles after each falling edge, and the bench puts 4 cycles between edges so both stay inside a half period. The bench drives pins and samples MISO only on falling system-clock edges. It checks memory contents only after chip select has gone high, when every strobe of the transfer has already happened. It sweeps every short address, writes the whole long space in one wrapping burst, and reads back with strided single reads and wrapping bursts.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
    localparam int BYTE_W   = 8;
    localparam int SHORT_AW = 6;
    localparam int LONG_AW  = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_HI,
        ST_CMD_LO,
        ST_WR_DATA,
        ST_RD_DATA
    } ctrl_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_pin,
    input  logic cs_n_pin,
    input  logic mosi_pin,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_idle,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_pipe, cs_pipe, mosi_pipe;
    logic              sck_last;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_pipe[i]  <= 1'b0;
                    cs_pipe[i]   <= 1'b1;
                    mosi_pipe[i] <= 1'b0;
                end else if (i == 0) begin
                    sck_pipe[i]  <= sck_pin;
                    cs_pipe[i]   <= cs_n_pin;
                    mosi_pipe[i] <= mosi_pin;
                end else begin
                    sck_pipe[i]  <= sck_pipe[i-1];
                    cs_pipe[i]   <= cs_pipe[i-1];
                    mosi_pipe[i] <= mosi_pipe[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_last <= 1'b0;
        else        sck_last <= sck_pipe[STAGES-1];
    end

    assign cs_idle  = cs_pipe[STAGES-1];
    assign mosi_s   = mosi_pipe[STAGES-1];
    assign sck_rise = !cs_idle &&  sck_pipe[STAGES-1] && !sck_last;
    assign sck_fall = !cs_idle && !sck_pipe[STAGES-1] &&  sck_last;
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_idle,
    input  logic              mosi_s,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            rx_byte   <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
        end else if (cs_idle) begin
            bit_cnt   <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (sck_rise) begin
                rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh[BYTE_W-2:0], mosi_s};
                end
            end
            if (load)
                tx_sh <= load_byte;
            else if (sck_fall && bit_cnt != '0)
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
    end

    assign miso = tx_sh[BYTE_W-1];
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
    import spi_reg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_idle,
    input  logic               byte_done,
    input  logic [BYTE_W-1:0]  rx_byte,
    output ctrl_state_t        state_o,
    output logic [LONG_AW-1:0] reg_addr,
    output logic               reg_space,
    output logic [BYTE_W-1:0]  reg_wdata,
    output logic               reg_we,
    output logic               reg_re,
    output logic               load
);
    ctrl_state_t        state_q, state_d;
    logic [BYTE_W-1:0]  hi_q;
    logic [LONG_AW-1:0] addr_nxt;

    always_comb begin
        if (reg_space) addr_nxt = reg_addr + 1'b1;
        else           addr_nxt = {{(LONG_AW-SHORT_AW){1'b0}}, reg_addr[SHORT_AW-1:0] + 1'b1};
    end

    always_comb begin
        state_d = state_q;
        if (cs_idle) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_CMD_HI;
                ST_CMD_HI:
                    if (byte_done) begin
                        if (rx_byte[7])      state_d = ST_CMD_LO;
                        else if (rx_byte[0]) state_d = ST_WR_DATA;
                        else                 state_d = ST_RD_DATA;
                    end
                ST_CMD_LO:
                    if (byte_done)
                        state_d = rx_byte[4] ? ST_WR_DATA : ST_RD_DATA;
                ST_WR_DATA: state_d = ST_WR_DATA;
                ST_RD_DATA: state_d = ST_RD_DATA;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q      <= '0;
            reg_addr  <= '0;
            reg_space <= 1'b0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
            load      <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            load   <= reg_re;
            if (reg_we) begin
                reg_addr <= addr_nxt;
            end else if (byte_done && !cs_idle) begin
                unique case (state_q)
                    ST_CMD_HI: begin
                        hi_q <= rx_byte;
                        if (!rx_byte[7]) begin
                            reg_space <= 1'b0;
                            reg_addr  <= {{(LONG_AW-SHORT_AW){1'b0}}, rx_byte[SHORT_AW:1]};
                            reg_re    <= !rx_byte[0];
                        end
                    end
                    ST_CMD_LO: begin
                        reg_space <= 1'b1;
                        reg_addr  <= {hi_q[6:0], rx_byte[7:5]};
                        reg_re    <= !rx_byte[4];
                    end
                    ST_WR_DATA: begin
                        reg_we    <= 1'b1;
                        reg_wdata <= rx_byte;
                    end
                    ST_RD_DATA: begin
                        reg_addr <= addr_nxt;
                        reg_re   <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/spi_dual_reg_slave.sv
module spi_dual_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         spi_sck,
    input  logic         spi_cs_n,
    input  logic         spi_mosi,
    output logic         spi_miso,
    output logic [9:0]   reg_addr,
    output logic         reg_space,
    output logic [7:0]   reg_wdata,
    output logic         reg_we,
    output logic         reg_re,
    input  logic [7:0]   reg_rdata
);
    logic        sck_rise, sck_fall, cs_idle, mosi_s;
    logic        byte_done, load;
    logic [7:0]  rx_byte;
    ctrl_state_t ctrl_state;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_pin  (spi_sck),
        .cs_n_pin (spi_cs_n),
        .mosi_pin (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_idle  (cs_idle),
        .mosi_s   (mosi_s)
    );

    spi_byte_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_idle   (cs_idle),
        .mosi_s    (mosi_s),
        .load      (load),
        .load_byte (reg_rdata),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    spi_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_idle   (cs_idle),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .state_o   (ctrl_state),
        .reg_addr  (reg_addr),
        .reg_space (reg_space),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .load      (load)
    );
endmodule

// File: rtl/spi_dual_reg_slave_chk.sv
module spi_dual_reg_slave_chk
    import spi_reg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        spi_miso,
    input logic [9:0]  reg_addr,
    input logic        reg_space,
    input logic        reg_we,
    input logic        reg_re,
    input ctrl_state_t state
);
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    p_we_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $stable(reg_addr));

    p_re_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    p_short_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !reg_space) |=>
            (reg_addr[5:0] == $past(reg_addr[5:0]) + 6'd1) && (reg_addr[9:6] == 4'd0));

    p_long_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_space) |=> (reg_addr == $past(reg_addr) + 10'd1));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (!reg_we && !reg_re && !spi_miso));
endmodule

bind spi_dual_reg_slave spi_dual_reg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_miso  (spi_miso),
    .reg_addr  (reg_addr),
    .reg_space (reg_space),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .state     (ctrl_state)
);

// File: tb/sim_spi_dual_reg_slave.sv
module sim_spi_dual_reg_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, csn = 1'b1, mosi = 1'b0;
    logic       miso;
    logic [9:0] reg_addr;
    logic       reg_space, reg_we, reg_re;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] short_mem [64];
    logic [7:0] long_mem  [1024];
    int         we_count = 0;
    int         checks = 0, fails = 0;
    bit         done = 1'b0;
    logic [7:0] txb [0:1100];
    logic [7:0] rxb [0:1100];

    always #10 clk = ~clk;

    spi_dual_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(csn), .spi_mosi(mosi),
        .spi_miso(miso), .reg_addr(reg_addr), .reg_space(reg_space),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (reg_we) begin
            we_count <= we_count + 1;
            if (reg_space) long_mem[reg_addr] <= reg_wdata;
            else           short_mem[reg_addr[5:0]] <= reg_wdata;
        end
        if (reg_re) reg_rdata <= reg_space ? long_mem[reg_addr] : short_mem[reg_addr[5:0]];
    end

    function automatic logic [7:0] sv(input int a);
        return 8'(a * 7 + 3) ^ 8'h5A;
    endfunction

    function automatic logic [7:0] lv(input int a);
        return 8'(a * 13 + (a >> 3));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits, output logic [7:0] r);
        r = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            mosi = b[i];
            wait_n(4);
            sck = 1'b1;
            r[i] = miso;
            wait_n(4);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input int n);
        logic [7:0] r;
        csn = 1'b0;
        wait_n(4);
        for (int k = 0; k < n; k++) begin
            send_bits(txb[k], 8, r);
            rxb[k] = r;
        end
        wait_n(4);
        csn = 1'b1;
        wait_n(8);
    endtask

    task automatic aborted(input logic [7:0] b0, input int nb0, input logic [7:0] b1, input int nb1);
        logic [7:0] r;
        csn = 1'b0;
        wait_n(4);
        send_bits(b0, nb0, r);
        if (nb1 > 0) send_bits(b1, nb1, r);
        wait_n(4);
        csn = 1'b1;
        wait_n(8);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int wc;
        bit clean;
        for (int i = 0; i < 64; i++) short_mem[i] = 8'h00;
        for (int i = 0; i < 1024; i++) long_mem[i] = 8'h00;
        reg_rdata = 8'h00;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        chk(miso == 1'b0 && !reg_we && !reg_re, "R8 reset", {miso, reg_we, reg_re}, 0);

        // R1 R3: short single writes at every address
        for (int a = 0; a < 64; a++) begin
            txb[0] = {1'b0, 6'(a), 1'b1};
            txb[1] = sv(a);
            xfer(2);
        end
        for (int a = 0; a < 64; a++) chk(short_mem[a] == sv(a), "R1 short write", short_mem[a], sv(a));
        chk(we_count == 64, "R3 one strobe per byte", we_count, 64);
        clean = 1'b1;
        for (int a = 0; a < 1024; a++) if (long_mem[a] != 8'h00) clean = 1'b0;
        chk(clean, "R1 long space untouched", clean, 1);

        // R5: short single reads
        for (int a = 0; a < 64; a++) begin
            txb[0] = {1'b0, 6'(a), 1'b0};
            txb[1] = 8'hFF;
            xfer(2);
            chk(rxb[1] == sv(a), "R5 short read", rxb[1], sv(a));
        end

        // R2 R4: long write burst over the whole space, starting near the top
        txb[0] = {1'b1, 7'(1000 >> 3)};
        txb[1] = {3'(1000), 1'b1, 4'hA};
        for (int i = 0; i < 1024; i++) txb[2 + i] = lv((1000 + i) % 1024);
        wc = we_count;
        xfer(1026);
        for (int a = 0; a < 1024; a++) chk(long_mem[a] == lv(a), "R4 long burst write", long_mem[a], lv(a));
        chk(we_count - wc == 1024, "R3 long burst strobes", we_count - wc, 1024);
        for (int a = 0; a < 64; a++) chk(short_mem[a] == sv(a), "R2 short space untouched", short_mem[a], sv(a));

        // R2 R5: strided long single reads, low nibble set
        for (int a = 0; a < 1024; a += 31) begin
            txb[0] = {1'b1, 7'(a >> 3)};
            txb[1] = {3'(a), 1'b0, 4'h5};
            txb[2] = 8'h00;
            xfer(3);
            chk(rxb[2] == lv(a), "R2 long read", rxb[2], lv(a));
        end

        // R6: long read burst wrapping past 1023
        txb[0] = {1'b1, 7'(1020 >> 3)};
        txb[1] = {3'(1020), 1'b0, 4'h0};
        for (int i = 0; i < 10; i++) txb[2 + i] = 8'h00;
        xfer(12);
        for (int i = 0; i < 10; i++)
            chk(rxb[2 + i] == lv((1020 + i) % 1024), "R6 long read burst", rxb[2 + i], lv((1020 + i) % 1024));

        // R6: short read burst wrapping past 63
        txb[0] = {1'b0, 6'd60, 1'b0};
        for (int i = 0; i < 8; i++) txb[1 + i] = 8'h00;
        xfer(9);
        for (int i = 0; i < 8; i++)
            chk(rxb[1 + i] == sv((60 + i) % 64), "R6 short read burst", rxb[1 + i], sv((60 + i) % 64));

        // R4: short write burst wrapping 62,63,0,1
        txb[0] = {1'b0, 6'd62, 1'b1};
        for (int i = 0; i < 4; i++) txb[1 + i] = 8'hC0 + 8'(i);
        xfer(5);
        for (int i = 0; i < 4; i++)
            chk(short_mem[(62 + i) % 64] == 8'hC0 + 8'(i), "R4 short burst wrap",
                short_mem[(62 + i) % 64], 8'hC0 + 8'(i));
        chk(short_mem[2] == sv(2), "R4 short burst stops", short_mem[2], sv(2));

        // R7: abort inside a data byte, then inside a command byte
        wc = we_count;
        aborted({1'b0, 6'd5, 1'b1}, 8, 8'h33, 5);
        chk(we_count == wc, "R7 no strobe on partial byte", we_count, wc);
        chk(short_mem[5] == sv(5), "R7 entry kept", short_mem[5], sv(5));
        aborted(8'hFF, 3, 8'h00, 0);
        txb[0] = {1'b0, 6'd5, 1'b0};
        txb[1] = 8'h00;
        xfer(2);
        chk(rxb[1] == sv(5), "R7 restart after abort", rxb[1], sv(5));
        chk(we_count == wc, "R7 no stray strobes", we_count, wc);
        chk(miso == 1'b0 && !reg_we && !reg_re, "R8 idle quiet", {miso, reg_we, reg_re}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule